// File: doc/BRIEF.md
# Trust-Domain Page Ownership Checker

This block sits between address translation and the memory path. Every translated request is checked against a table that holds one record per 4 KB physical page. Each record stores the owning domain identifier, the guest page frame the page is expected to back, a key index and an epoch counter. A request is either granted, with the record's key index placed in the address bits above the platform address width, or refused with a fault code.

Guest physical address bit 51 selects whether the ownership check applies. When it is 0 the request is private and is checked. When it is 1 the request is shared and passes unchecked. Requests issued outside trust-domain context, such as host or hypervisor accesses, are never checked and never fault. They always carry key index 0, so reading a private page gives ciphertext rather than a probeable fault.

Ownership faults are reported on a fault line that belongs to the secure management agent. A separate hypervisor-facing line reports only requests whose physical frame lies beyond the table. Only a writer in secure mode can change the table.

Top module: `dom_page_guard`

## Requirements
- R1: After reset every record has owner 0, guest frame 0, key 0 and epoch 0. After reset `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. Its response is valid from the next rising edge. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and `req_ready` is low.
- R3: A private trust-domain request (`req_secure`=1, GPA bit 51 = 0) is refused with `rsp_grant`=0. The checks run in this order and the first failure sets `rsp_fault`: fault 1 if the record owner differs from `req_dom`; fault 2 if the record's guest frame differs from GPA bits 50:12; fault 3 if the owner is 0 (unassigned).
- R4: A private trust-domain request that passes all checks is granted with fault 0 and `rsp_key` equal to the record's key. In that case `rsp_addr` = {key, `req_hpa`}.
- R5: A trust-domain request with GPA bit 51 = 1 is granted with fault 0 and key 0 whatever the record holds.
- R6: A request with `req_secure`=0 is granted with fault 0 and key 0, even when it targets a private page owned by another domain.
- R7: `sec_fault` is high exactly while a valid response carries a nonzero fault code. `hv_fault` is never high together with `sec_fault`.
- R8: A request whose physical frame index is not below `PAGE_CNT` is refused with fault 0, key 0 and epoch 0, and `hv_fault` is raised.
- R9: A table write (`md_we`) takes effect only when `md_secure` is high. Otherwise the record keeps all its fields.
- R10: An accepted table write that changes a record's owner increments its epoch, modulo 2^`EP_W`. A write that keeps the owner leaves the epoch unchanged. Every in-range response reports the epoch in `rsp_epoch`.
- R11: A table write and a lookup of the same page in the same cycle give a response built from the record as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_dom | input | DOM_W | Requesting domain identifier |
| req_gpage | input | SHARE_BIT-11 | Guest physical address bits SHARE_BIT..12 |
| req_hpa | input | PHYS_W | Translated host physical address |
| req_secure | input | 1 | Request issued in trust-domain context |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_grant | output | 1 | Request may proceed |
| rsp_fault | output | 2 | 0 none, 1 owner, 2 guest frame, 3 unassigned |
| rsp_key | output | KEY_W | Key index applied |
| rsp_epoch | output | EP_W | Epoch of the addressed record |
| rsp_addr | output | PHYS_W+KEY_W | Host address with key index on top |
| sec_fault | output | 1 | Ownership fault to the secure agent |
| hv_fault | output | 1 | Out-of-table frame to the hypervisor |
| md_we | input | 1 | Table write strobe |
| md_secure | input | 1 | Writer is in secure mode |
| md_idx | input | log2(PAGE_CNT) | Page frame to write |
| md_owner | input | DOM_W | New owner |
| md_gfn | input | SHARE_BIT-12 | New expected guest frame |
| md_key | input | KEY_W | New key index |

## Verification
A table write and a lookup can hit the same page in one cycle. The bench provokes this by driving both on the same clock edge, first with an owner change on page 6 and then with a rejected non-secure write. It judges the same-cycle response against the record held before the write, then confirms with a second lookup that the new record (or the unchanged one) is in force. A response held under back-pressure is also compared cycle by cycle against its expected value while the request port stays closed.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
   localparam int PG_SHIFT = 12;

   typedef enum logic [1:0] {
      FC_NONE       = 2'd0,
      FC_OWNER      = 2'd1,
      FC_GADDR      = 2'd2,
      FC_UNASSIGNED = 2'd3
   } fault_code_e;
endpackage

// File: rtl/dpg_meta_ram.sv
module dpg_meta_ram #(
   parameter int PAGE_CNT = 64,
   parameter int IDX_W    = 6,
   parameter int DOM_W    = 16,
   parameter int GFN_W    = 39,
   parameter int KEY_W    = 6,
   parameter int EP_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_secure,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DOM_W-1:0] wr_owner,
   input  logic [GFN_W-1:0] wr_gfn,
   input  logic [KEY_W-1:0] wr_key,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [DOM_W-1:0] rd_owner,
   output logic [GFN_W-1:0] rd_gfn,
   output logic [KEY_W-1:0] rd_key,
   output logic [EP_W-1:0]  rd_epoch
);
   logic [DOM_W-1:0] own_q [PAGE_CNT];
   logic [GFN_W-1:0] gfn_q [PAGE_CNT];
   logic [KEY_W-1:0] key_q [PAGE_CNT];
   logic [EP_W-1:0]  ep_q  [PAGE_CNT];

   logic wr_ok;
   logic owner_moves;

   // Only a secure-mode writer may touch the table.
   assign wr_ok       = wr_en && wr_secure;
   assign owner_moves = (own_q[wr_idx] != wr_owner);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE_CNT; i++) begin
            own_q[i] <= '0;
            gfn_q[i] <= '0;
            key_q[i] <= '0;
            ep_q[i]  <= '0;
         end
      end else if (wr_ok) begin
         own_q[wr_idx] <= wr_owner;
         gfn_q[wr_idx] <= wr_gfn;
         key_q[wr_idx] <= wr_key;
         if (owner_moves) begin
            ep_q[wr_idx] <= ep_q[wr_idx] + EP_W'(1);
         end
      end
   end

   // Registered read. The array update above is non-blocking, so a
   // same-cycle read returns the record as it stood before the write.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_owner <= '0;
         rd_gfn   <= '0;
         rd_key   <= '0;
         rd_epoch <= '0;
      end else if (rd_en) begin
         rd_owner <= own_q[rd_idx];
         rd_gfn   <= gfn_q[rd_idx];
         rd_key   <= key_q[rd_idx];
         rd_epoch <= ep_q[rd_idx];
      end
   end
endmodule

// File: rtl/dpg_judge.sv
module dpg_judge #(
   parameter int DOM_W = 16,
   parameter int GFN_W = 39,
   parameter int KEY_W = 6,
   parameter int EP_W  = 8
) (
   input  logic                 in_range,
   input  logic                 host,
   input  logic                 shared,
   input  logic [DOM_W-1:0]     req_dom,
   input  logic [GFN_W-1:0]     req_gfn,
   input  logic [DOM_W-1:0]     ent_owner,
   input  logic [GFN_W-1:0]     ent_gfn,
   input  logic [KEY_W-1:0]     ent_key,
   input  logic [EP_W-1:0]      ent_epoch,
   output logic                 grant,
   output dpg_pkg::fault_code_e code,
   output logic [KEY_W-1:0]     key,
   output logic [EP_W-1:0]      epoch,
   output logic                 hv
);
   import dpg_pkg::*;

   always_comb begin
      grant = 1'b0;
      code  = FC_NONE;
      key   = '0;
      epoch = '0;
      hv    = 1'b0;
      if (!in_range) begin
         hv = 1'b1;
      end else begin
         epoch = ent_epoch;
         if (host || shared) begin
            // Unchecked path: always the default key, never a fault.
            grant = 1'b1;
         end else if (ent_owner != req_dom) begin
            code = FC_OWNER;
         end else if (ent_gfn != req_gfn) begin
            code = FC_GADDR;
         end else if (ent_owner == '0) begin
            code = FC_UNASSIGNED;
         end else begin
            grant = 1'b1;
            key   = ent_key;
         end
      end
   end
endmodule

// File: rtl/dom_page_guard.sv
module dom_page_guard import dpg_pkg::*; #(
   parameter int   PAGE_CNT  = 64,
   parameter int   DOM_W     = 16,
   parameter int   SHARE_BIT = 51,
   parameter int   PHYS_W    = 46,
   parameter int   KEY_W     = 6,
   parameter int   EP_W      = 8,
   localparam int  IDX_W     = $clog2(PAGE_CNT),
   localparam int  GFN_W     = SHARE_BIT - PG_SHIFT,
   localparam int  OUT_W     = PHYS_W + KEY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DOM_W-1:0]  req_dom,
   input  logic [GFN_W:0]    req_gpage,
   input  logic [PHYS_W-1:0] req_hpa,
   input  logic              req_secure,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_grant,
   output logic [1:0]        rsp_fault,
   output logic [KEY_W-1:0]  rsp_key,
   output logic [EP_W-1:0]   rsp_epoch,
   output logic [OUT_W-1:0]  rsp_addr,
   output logic              sec_fault,
   output logic              hv_fault,
   input  logic              md_we,
   input  logic              md_secure,
   input  logic [IDX_W-1:0]  md_idx,
   input  logic [DOM_W-1:0]  md_owner,
   input  logic [GFN_W-1:0]  md_gfn,
   input  logic [KEY_W-1:0]  md_key
);
   localparam int HI_W = PHYS_W - PG_SHIFT - IDX_W;

   // Elaboration-time parameter checks
   if (KEY_W < 4 || KEY_W > 15) begin : g_bad_key
      $error("KEY_W must lie in 4..15");
   end
   if ((1 << IDX_W) != PAGE_CNT) begin : g_bad_pages
      $error("PAGE_CNT must be a power of two");
   end
   if (HI_W < 0) begin : g_bad_phys
      $error("PHYS_W too small for PAGE_CNT");
   end
   if (SHARE_BIT <= PG_SHIFT) begin : g_bad_share
      $error("SHARE_BIT must lie above the page offset");
   end

   // Request-side decode
   logic             req_inrange;
   logic             advance;
   logic             accept;
   logic [IDX_W-1:0] req_idx;

   if (HI_W > 0) begin : g_range
      assign req_inrange = (req_hpa[PHYS_W-1 -: HI_W] == '0);
   end else begin : g_full
      assign req_inrange = 1'b1;
   end

   assign req_idx   = req_hpa[PG_SHIFT +: IDX_W];
   assign advance   = !rsp_valid || rsp_ready;
   assign req_ready = advance;
   assign accept    = req_valid && advance;

   // Stage 1: request fields alongside the table read
   logic              s1_valid;
   logic              s1_host;
   logic              s1_shared;
   logic              s1_inrange;
   logic [DOM_W-1:0]  s1_dom;
   logic [GFN_W-1:0]  s1_gfn;
   logic [PHYS_W-1:0] s1_hpa;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid   <= 1'b0;
         s1_host    <= 1'b0;
         s1_shared  <= 1'b0;
         s1_inrange <= 1'b0;
         s1_dom     <= '0;
         s1_gfn     <= '0;
         s1_hpa     <= '0;
      end else if (advance) begin
         s1_valid   <= req_valid;
         s1_host    <= !req_secure;
         s1_shared  <= req_gpage[GFN_W];
         s1_inrange <= req_inrange;
         s1_dom     <= req_dom;
         s1_gfn     <= req_gpage[GFN_W-1:0];
         s1_hpa     <= req_hpa;
      end
   end

   logic [DOM_W-1:0] ent_owner;
   logic [GFN_W-1:0] ent_gfn;
   logic [KEY_W-1:0] ent_key;
   logic [EP_W-1:0]  ent_epoch;

   dpg_meta_ram #(
      .PAGE_CNT (PAGE_CNT),
      .IDX_W    (IDX_W),
      .DOM_W    (DOM_W),
      .GFN_W    (GFN_W),
      .KEY_W    (KEY_W),
      .EP_W     (EP_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (md_we),
      .wr_secure (md_secure),
      .wr_idx    (md_idx),
      .wr_owner  (md_owner),
      .wr_gfn    (md_gfn),
      .wr_key    (md_key),
      .rd_en     (accept),
      .rd_idx    (req_idx),
      .rd_owner  (ent_owner),
      .rd_gfn    (ent_gfn),
      .rd_key    (ent_key),
      .rd_epoch  (ent_epoch)
   );

   logic             j_grant;
   fault_code_e      j_code;
   logic [KEY_W-1:0] j_key;
   logic [EP_W-1:0]  j_epoch;
   logic             j_hv;

   dpg_judge #(
      .DOM_W (DOM_W),
      .GFN_W (GFN_W),
      .KEY_W (KEY_W),
      .EP_W  (EP_W)
   ) u_judge (
      .in_range  (s1_inrange),
      .host      (s1_host),
      .shared    (s1_shared),
      .req_dom   (s1_dom),
      .req_gfn   (s1_gfn),
      .ent_owner (ent_owner),
      .ent_gfn   (ent_gfn),
      .ent_key   (ent_key),
      .ent_epoch (ent_epoch),
      .grant     (j_grant),
      .code      (j_code),
      .key       (j_key),
      .epoch     (j_epoch),
      .hv        (j_hv)
   );

   // Stage 2: response register
   logic        rsp_valid_q;
   logic        grant_q;
   fault_code_e code_q;
   logic        hv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         grant_q     <= 1'b0;
         code_q      <= FC_NONE;
         hv_q        <= 1'b0;
         rsp_key     <= '0;
         rsp_epoch   <= '0;
         rsp_addr    <= '0;
      end else if (advance) begin
         rsp_valid_q <= s1_valid;
         grant_q     <= j_grant;
         code_q      <= j_code;
         hv_q        <= j_hv;
         rsp_key     <= j_key;
         rsp_epoch   <= j_epoch;
         rsp_addr    <= {j_key, s1_hpa};
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_grant = grant_q;
   assign rsp_fault = code_q;
   assign sec_fault = rsp_valid_q && (code_q != FC_NONE);
   assign hv_fault  = rsp_valid_q && hv_q;
endmodule

// File: rtl/dpg_chk.sv
module dpg_chk #(
   parameter int KEY_W = 6,
   parameter int OUT_W = 52
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic             rsp_grant,
   input logic [1:0]       rsp_fault,
   input logic [KEY_W-1:0] rsp_key,
   input logic [OUT_W-1:0] rsp_addr,
   input logic             sec_fault,
   input logic             hv_fault
);
   p_fault_denies_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> !rsp_grant);

   p_hv_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sec_fault |-> !hv_fault);

   p_hv_denies_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hv_fault |-> (!rsp_grant && rsp_fault == 2'd0 && rsp_key == '0));

   p_deny_nokey_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_grant) |-> (rsp_key == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault) && $stable(rsp_grant)));

   p_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind dom_page_guard dpg_chk #(
   .KEY_W (KEY_W),
   .OUT_W (PHYS_W + KEY_W)
) u_dpg_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_grant (rsp_grant),
   .rsp_fault (rsp_fault),
   .rsp_key   (rsp_key),
   .rsp_addr  (rsp_addr),
   .sec_fault (sec_fault),
   .hv_fault  (hv_fault)
);

// File: tb/dom_page_guard_tb_top.sv
module dom_page_guard_tb_top;
   localparam int PAGES = 16;
   localparam int PW    = 20;
   localparam int KW    = 4;
   localparam int EW    = 4;
   localparam int GW    = 39;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          req_valid = 1'b0, req_secure = 1'b0, rsp_ready = 1'b1;
   logic          req_ready, rsp_valid, rsp_grant, sec_fault, hv_fault;
   logic [15:0]   req_dom = '0;
   logic [GW:0]   req_gpage = '0;
   logic [PW-1:0] req_hpa = '0;
   logic [1:0]    rsp_fault;
   logic [KW-1:0] rsp_key;
   logic [EW-1:0] rsp_epoch;
   logic [PW+KW-1:0] rsp_addr;
   logic          md_we = 1'b0, md_secure = 1'b0;
   logic [3:0]    md_idx = '0;
   logic [15:0]   md_owner = '0;
   logic [GW-1:0] md_gfn = '0;
   logic [KW-1:0] md_key = '0;

   dom_page_guard #(
      .PAGE_CNT (PAGES), .DOM_W (16), .SHARE_BIT (51),
      .PHYS_W (PW), .KEY_W (KW), .EP_W (EW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_dom (req_dom),
      .req_gpage (req_gpage), .req_hpa (req_hpa), .req_secure (req_secure),
      .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_grant (rsp_grant),
      .rsp_fault (rsp_fault), .rsp_key (rsp_key), .rsp_epoch (rsp_epoch),
      .rsp_addr (rsp_addr), .sec_fault (sec_fault), .hv_fault (hv_fault),
      .md_we (md_we), .md_secure (md_secure), .md_idx (md_idx),
      .md_owner (md_owner), .md_gfn (md_gfn), .md_key (md_key)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0]   m_own [PAGES];
   logic [GW-1:0] m_gfn [PAGES];
   logic [KW-1:0] m_key [PAGES];
   logic [EW-1:0] m_ep  [PAGES];

   // packed response: grant, fault, hv, sec, key, epoch, addr
   function automatic logic [36:0] expect_rsp(input int dom, input bit sh,
                                             input int gfn, input int frame,
                                             input bit sec);
      logic [PW-1:0] hpa;
      logic [1:0]    code;
      hpa = {frame[7:0], 12'h3a0};
      if (frame >= PAGES) return {1'b0, 2'd0, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0, hpa};
      if (!sec || sh) return {1'b1, 2'd0, 1'b0, 1'b0, 4'd0, m_ep[frame], 4'd0, hpa};
      if (m_own[frame] != 16'(dom))       code = 2'd1;
      else if (m_gfn[frame] != GW'(gfn))  code = 2'd2;
      else if (m_own[frame] == 16'd0)     code = 2'd3;
      else code = 2'd0;
      if (code != 2'd0) return {1'b0, code, 1'b0, 1'b1, 4'd0, m_ep[frame], 4'd0, hpa};
      return {1'b1, 2'd0, 1'b0, 1'b0, m_key[frame], m_ep[frame], m_key[frame], hpa};
   endfunction

   function automatic logic [36:0] actual_rsp();
      return {rsp_grant, rsp_fault, hv_fault, sec_fault, rsp_key, rsp_epoch, rsp_addr};
   endfunction

   task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive_req(input int dom, input bit sh, input int gfn,
                            input int frame, input bit sec);
      req_valid  = 1'b1;
      req_dom    = 16'(dom);
      req_gpage  = {sh, GW'(gfn)};
      req_hpa    = {frame[7:0], 12'h3a0};
      req_secure = sec;
   endtask

   task automatic lookup(input string tag, input int dom, input bit sh,
                         input int gfn, input int frame, input bit sec);
      logic [36:0] exp;
      exp = expect_rsp(dom, sh, gfn, frame, sec);
      @(negedge clk);
      drive_req(dom, sh, gfn, frame, sec);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (!rsp_valid) begin
         checks++; errors++;
         $display("FAIL %s actual=rsp_valid 0 expected=rsp_valid 1", tag);
      end else check(tag, actual_rsp(), exp);
   endtask

   task automatic table_write(input bit sec, input int p, input int owner,
                              input int gfn, input int key);
      @(negedge clk);
      md_we = 1'b1; md_secure = sec; md_idx = 4'(p);
      md_owner = 16'(owner); md_gfn = GW'(gfn); md_key = KW'(key);
      @(posedge clk);
      @(negedge clk);
      md_we = 1'b0; md_secure = 1'b0;
      if (sec) begin
         if (m_own[p] != 16'(owner)) m_ep[p] = m_ep[p] + 4'd1;
         m_own[p] = 16'(owner); m_gfn[p] = GW'(gfn); m_key[p] = KW'(key);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [36:0] exp;
      for (int i = 0; i < PAGES; i++) begin
         m_own[i] = '0; m_gfn[i] = '0; m_key[i] = '0; m_ep[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state of the handshake
      check("R1 handshake", {35'd0, rsp_valid, req_ready}, {35'd0, 1'b0, 1'b1});
      check("R1 fault lines", {35'd0, sec_fault, hv_fault}, 37'd0);
      // R1: every record unassigned (dom 0 gfn 0 reaches code 3)
      for (int p = 0; p < PAGES; p++) lookup("R1/R3 reset record", 0, 1'b0, 0, p, 1'b1);

      // R9: non-secure writes are dropped
      for (int p = 0; p < PAGES; p++) table_write(1'b0, p, p + 1, p, p);
      for (int p = 0; p < PAGES; p++) lookup("R9 nonsecure write ignored", 0, 1'b0, 0, p, 1'b1);

      // populate: owner p%4 (0 stays unassigned), gfn 3p+1, key (7p+3)%16
      for (int p = 0; p < PAGES; p++) table_write(1'b1, p, p % 4, 3 * p + 1, (7 * p + 3) % 16);

      // sweep: R3 R4 private, R5 shared, R6 host, R7 fault routing
      for (int p = 0; p < PAGES; p++) begin
         for (int d = 0; d < 5; d++) begin
            lookup("R3/R4/R7 private match", d, 1'b0, 3 * p + 1, p, 1'b1);
            lookup("R3/R7 private wrong frame", d, 1'b0, 3 * p + 2, p, 1'b1);
            lookup("R5 shared", d, 1'b1, 3 * p + 2, p, 1'b1);
            lookup("R6 host", d, 1'b0, 3 * p + 1, p, 1'b0);
         end
      end

      // R8: frames beyond the table
      lookup("R8 out of table", 1, 1'b0, 4, 16, 1'b1);
      lookup("R8 out of table", 3, 1'b0, 4, 100, 1'b1);
      lookup("R8 out of table host", 0, 1'b0, 0, 255, 1'b0);

      // R10: epoch moves only on owner change, wraps modulo 16
      table_write(1'b1, 1, 5, 4, 9);
      lookup("R10 owner change", 0, 1'b0, 4, 1, 1'b0);
      table_write(1'b1, 1, 5, 8, 2);
      lookup("R10 same owner", 0, 1'b0, 8, 1, 1'b0);
      lookup("R4 rewritten record", 5, 1'b0, 8, 1, 1'b1);
      for (int k = 0; k < 17; k++) begin
         table_write(1'b1, 1, (k % 2 == 0) ? 6 : 5, 8, 2);
         lookup("R10 epoch wrap", 0, 1'b0, 8, 1, 1'b0);
      end

      // R11: same-cycle write and lookup of page 6 (owner 2, gfn 19)
      exp = expect_rsp(2, 1'b0, 19, 6, 1'b1);
      @(negedge clk);
      md_we = 1'b1; md_secure = 1'b1; md_idx = 4'd6;
      md_owner = 16'd9; md_gfn = GW'(19); md_key = KW'(1);
      drive_req(2, 1'b0, 19, 6, 1'b1);
      @(posedge clk);
      @(negedge clk);
      md_we = 1'b0; md_secure = 1'b0; req_valid = 1'b0;
      m_own[6] = 16'd9; m_key[6] = 4'd1; m_ep[6] = m_ep[6] + 4'd1;
      @(posedge clk);
      @(negedge clk);
      check("R11 same-cycle sees old record", actual_rsp(), exp);
      lookup("R11 new record after write", 9, 1'b0, 19, 6, 1'b1);
      lookup("R11 old owner now refused", 2, 1'b0, 19, 6, 1'b1);
      // R9/R11: rejected write alongside a lookup
      exp = expect_rsp(9, 1'b0, 19, 6, 1'b1);
      @(negedge clk);
      md_we = 1'b1; md_secure = 1'b0; md_idx = 4'd6; md_owner = 16'd4;
      drive_req(9, 1'b0, 19, 6, 1'b1);
      @(posedge clk);
      @(negedge clk);
      md_we = 1'b0; req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R9/R11 rejected same-cycle", actual_rsp(), exp);
      lookup("R9 record kept", 9, 1'b0, 19, 6, 1'b1);

      // R2: back-pressure holds the response and closes the port
      exp = expect_rsp(3, 1'b0, 10, 3, 1'b1);
      @(negedge clk);
      rsp_ready = 1'b0;
      drive_req(3, 1'b0, 10, 3, 1'b1);
      @(posedge clk);
      @(negedge clk);
      drive_req(1, 1'b0, 4, 1, 1'b1);
      for (int c = 0; c < 3; c++) begin
         @(posedge clk);
         @(negedge clk);
         check("R2 held response", actual_rsp(), exp);
         check("R2 port closed", {35'd0, rsp_valid, req_ready}, {35'd0, 1'b1, 1'b0});
      end
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R2 drained", {36'd0, rsp_valid}, 37'd1);
      exp = expect_rsp(1, 1'b0, 4, 1, 1'b1);
      check("R2 queued request", actual_rsp(), exp);
      @(posedge clk);
      @(negedge clk);
      check("R2 empty", {36'd0, rsp_valid}, 37'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule